// File: doc/BRIEF.md
# Three-Agent Ownership Semaphore

This block is a small hardware semaphore that lets three agents (a software driver, a manageability controller and an on-chip hardware sequencer) take turns on a shared management bus and a shared non-volatile memory port. Each agent has one ownership bit. To ask for ownership, an agent writes 1 to its own bit. It then reads the bit back. A 1 means the agent holds the resource. A 0 means the request was refused.

A request is only accepted when nobody else holds the semaphore. The hardware sequencer uses the same mechanism: it holds its bit for the whole time it loads the extended configuration area, and writes 0 when the load is done. The semaphore is advisory. Nothing in this block blocks an access to the shared resources. It only records and reports who the owner is. A one-hot grant vector mirrors the bits, so the downstream bus and memory paths can see the current owner.

The block has two reset domains. The normal device reset clears the software and hardware bits. The manageability bit survives that reset and is cleared only by the power-good reset or by the manageability agent itself.

Top module: `own_sem_top`

## Requirements
- R1: While `pwr_rst` is sampled high at a clock edge, all three ownership bits are 0 after that edge. `own_rd` bit 0 is software, bit 1 is manageability and bit 2 is hardware.
- R2: While `dev_rst` is sampled high, the software and hardware bits become 0 and writes from those two agents are ignored. The manageability bit is not reset; it keeps evolving under its own writes, following the same rules as in normal operation.
- R3: When all bits are 0, a single agent writing 1 (its `*_we` high with `*_wd` = 1) finds its bit read back as 1 after the next clock edge.
- R4: An agent writing 1 while another agent's bit is 1 at that edge leaves its own bit at 0.
- R5: At no time is more than one of the three bits 1.
- R6: The owner writing 0 clears its bit at the next edge, and afterwards another agent can acquire ownership.
- R7: A write of 0 from an agent that does not own the semaphore changes no bit, and a write of 1 from the current owner keeps its bit at 1.
- R8: When several agents write 1 in the same cycle while all bits are 0, only one wins, in the priority order hardware, then manageability, then software. The losing bits stay 0.
- R9: `grant_oh` equals `own_rd` in every cycle, and it is either one-hot or all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwr_rst | input | 1 | Synchronous active-high power-good reset; clears every bit |
| dev_rst | input | 1 | Synchronous active-high device reset; clears software and hardware bits |
| sw_we | input | 1 | Software write strobe for its ownership bit |
| sw_wd | input | 1 | Software write value |
| mg_we | input | 1 | Manageability write strobe for its ownership bit |
| mg_wd | input | 1 | Manageability write value |
| hw_we | input | 1 | Hardware sequencer write strobe for its ownership bit |
| hw_wd | input | 1 | Hardware sequencer write value |
| own_rd | output | 3 | Read-back of the ownership bits {hw, mg, sw} |
| grant_oh | output | 3 | One-hot grant vector mirroring the ownership bits |

## Verification
The assertions check on every cycle that at most one bit is set, that a refused request leaves its bit clear, that an owner's release and a bystander's write of 0 behave as required, that the power-good reset empties the register, that the manageability bit survives the device reset, and that hardware wins a contest from an empty state. Only the bench's scenarios show the complete acquire, refuse, release and hand-over sequences from the agents' point of view. They also show the full priority order among every pair of contenders, and the read-back values across both reset domains.

// File: rtl/own_sem_pkg.sv
package own_sem_pkg;

    localparam int unsigned N_AGENT = 3;

    typedef enum logic [1:0] {
        AG_SW = 2'd0,
        AG_MG = 2'd1,
        AG_HW = 2'd2
    } agent_e;

    typedef logic [N_AGENT-1:0] own_vec_t;

    typedef struct packed {
        logic en;
        logic data;
    } wr_t;

    // Agents cleared by the device reset (software and hardware).
    localparam own_vec_t DEV_DOMAIN = own_vec_t'((1 << AG_SW) | (1 << AG_HW));

    // Highest index wins: hardware over manageability over software.
    function automatic own_vec_t pick_top(input own_vec_t req);
        own_vec_t res;
        res = '0;
        for (int i = 0; i < N_AGENT; i++) begin
            if (req[i]) res = own_vec_t'(1 << i);
        end
        return res;
    endfunction

endpackage

// File: rtl/own_sem_req.sv
module own_sem_req
    import own_sem_pkg::*;
#(
    parameter int unsigned N = N_AGENT
) (
    input  wr_t [N-1:0]  wr,
    input  logic [N-1:0] suppress,
    output logic [N-1:0] set_req,
    output logic [N-1:0] clr_req
);

    for (genvar g = 0; g < N; g++) begin : g_agent
        always_comb begin
            set_req[g] = wr[g].en &  wr[g].data & ~suppress[g];
            clr_req[g] = wr[g].en & ~wr[g].data & ~suppress[g];
        end
    end

endmodule

// File: rtl/own_sem_arb.sv
module own_sem_arb
    import own_sem_pkg::*;
(
    input  own_vec_t own_q,
    input  own_vec_t set_req,
    input  own_vec_t clr_req,
    output own_vec_t own_d
);

    always_comb begin
        if (own_q != '0) begin
            // Held: only the owner's release matters; other bits stay clear.
            own_d = own_q & ~clr_req;
        end else begin
            own_d = pick_top(set_req);
        end
    end

endmodule

// File: rtl/own_sem_top.sv
module own_sem_top
    import own_sem_pkg::*;
(
    input  logic       clk,
    input  logic       pwr_rst,
    input  logic       dev_rst,
    input  logic       sw_we,
    input  logic       sw_wd,
    input  logic       mg_we,
    input  logic       mg_wd,
    input  logic       hw_we,
    input  logic       hw_wd,
    output logic [2:0] own_rd,
    output logic [2:0] grant_oh
);

    wr_t [N_AGENT-1:0] wr;
    own_vec_t          suppress;
    own_vec_t          set_req;
    own_vec_t          clr_req;
    own_vec_t          own_d;
    own_vec_t          own_q;

    always_comb begin
        wr[AG_SW] = '{en: sw_we, data: sw_wd};
        wr[AG_MG] = '{en: mg_we, data: mg_wd};
        wr[AG_HW] = '{en: hw_we, data: hw_wd};
        suppress  = dev_rst ? DEV_DOMAIN : '0;
    end

    own_sem_req #(.N(N_AGENT)) u_req (
        .wr       (wr),
        .suppress (suppress),
        .set_req  (set_req),
        .clr_req  (clr_req)
    );

    own_sem_arb u_arb (
        .own_q   (own_q),
        .set_req (set_req),
        .clr_req (clr_req),
        .own_d   (own_d)
    );

    always_ff @(posedge clk) begin
        if (pwr_rst) begin
            own_q <= '0;
        end else if (dev_rst) begin
            own_q <= own_d & ~DEV_DOMAIN;
        end else begin
            own_q <= own_d;
        end
    end

    assign own_rd   = own_q;
    assign grant_oh = own_q;

    assert_onehot_R5: assert property (@(posedge clk) disable iff (pwr_rst)
        $onehot0(own_q));

    assert_pwr_clear_R1: assert property (@(posedge clk)
        pwr_rst |=> (own_q == '0));

    assert_mg_keep_R2: assert property (@(posedge clk) disable iff (pwr_rst)
        (dev_rst && !mg_we) |=> (own_q[AG_MG] == $past(own_q[AG_MG])));

    assert_dev_clear_R2: assert property (@(posedge clk) disable iff (pwr_rst)
        dev_rst |=> (!own_q[AG_SW] && !own_q[AG_HW]));

    assert_refused_R4: assert property (@(posedge clk) disable iff (pwr_rst || dev_rst)
        (sw_we && sw_wd && (own_q[AG_MG] || own_q[AG_HW])) |=> !own_q[AG_SW]);

    assert_release_R6: assert property (@(posedge clk) disable iff (pwr_rst || dev_rst)
        (own_q[AG_MG] && mg_we && !mg_wd) |=> (own_q == '0));

    assert_bystander_R7: assert property (@(posedge clk) disable iff (pwr_rst || dev_rst)
        (own_q[AG_HW] && sw_we && !sw_wd && !(hw_we && !hw_wd)) |=> own_q[AG_HW]);

    assert_hw_wins_R8: assert property (@(posedge clk) disable iff (pwr_rst || dev_rst)
        ((own_q == '0) && hw_we && hw_wd) |=> own_q[AG_HW]);

endmodule

// File: tb/own_sem_top_test.sv
module own_sem_top_test;

    logic       clk = 1'b0;
    logic       pwr_rst, dev_rst;
    logic       sw_we, sw_wd, mg_we, mg_wd, hw_we, hw_wd;
    logic [2:0] own_rd, grant_oh;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    own_sem_top uut (
        .clk(clk), .pwr_rst(pwr_rst), .dev_rst(dev_rst),
        .sw_we(sw_we), .sw_wd(sw_wd), .mg_we(mg_we), .mg_wd(mg_wd),
        .hw_we(hw_we), .hw_wd(hw_wd), .own_rd(own_rd), .grant_oh(grant_oh)
    );

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // One clock: drive at negedge, sample 1 ns after the posedge.
    task automatic step(input logic swe, input logic swd, input logic mge, input logic mgd,
                        input logic hwe, input logic hwd, input logic drst, input logic prst);
        @(negedge clk);
        sw_we = swe; sw_wd = swd; mg_we = mge; mg_wd = mgd; hw_we = hwe; hw_wd = hwd;
        dev_rst = drst; pwr_rst = prst;
        @(posedge clk);
        #1;
        sw_we = 0; sw_wd = 0; mg_we = 0; mg_wd = 0; hw_we = 0; hw_wd = 0;
        dev_rst = 0; pwr_rst = 0;
    endtask

    task automatic check(input logic [2:0] exp, input string tag);
        n_chk++;
        if (own_rd !== exp) begin
            n_fail++;
            $display("FAIL %s own_rd actual=%b expected=%b", tag, own_rd, exp);
        end
        n_chk++;
        if (grant_oh !== exp) begin
            n_fail++;
            $display("FAIL R9 (%s) grant_oh actual=%b expected=%b", tag, grant_oh, exp);
        end
    endtask

    task automatic t_reset;
        step(0,0,0,0,0,0,0,1);
        check(3'b000, "R1 power-good reset");
    endtask

    task automatic t_sw_cycle;
        step(1,1,0,0,0,0,0,0); check(3'b001, "R3 sw acquire");
        step(0,0,1,1,0,0,0,0); check(3'b001, "R4 mg refused");
        step(0,0,0,0,1,1,0,0); check(3'b001, "R4 hw refused");
        step(0,0,1,0,0,0,0,0); check(3'b001, "R7 mg write0 bystander");
        step(1,1,0,0,0,0,0,0); check(3'b001, "R7 sw rewrite1 keeps");
        step(1,0,1,1,0,0,0,0); check(3'b000, "R6 sw release, same-cycle mg refused");
        step(0,0,1,1,0,0,0,0); check(3'b010, "R6 mg acquires after release");
        step(0,0,1,0,0,0,0,0); check(3'b000, "R6 mg release");
    endtask

    task automatic t_hw_load;
        step(0,0,0,0,1,1,0,0); check(3'b100, "R3 hw acquire for config load");
        for (int i = 0; i < 4; i++) begin
            step(1,1,1,0,0,0,0,0); check(3'b100, "R4 hw held during load");
        end
        step(0,0,0,0,1,0,0,0); check(3'b000, "R6 hw release after load");
    endtask

    task automatic t_dev_reset;
        step(0,0,1,1,0,0,0,0); check(3'b010, "R3 mg acquire");
        step(0,0,0,0,0,0,1,0); check(3'b010, "R2 mg survives dev reset");
        step(0,0,1,0,0,0,1,0); check(3'b000, "R2 mg release during dev reset");
        step(0,0,0,0,1,1,0,0); check(3'b100, "R3 hw acquire");
        step(0,0,0,0,0,0,1,0); check(3'b000, "R2 hw cleared by dev reset");
        step(1,1,0,0,0,0,1,0); check(3'b000, "R2 sw write ignored in dev reset");
        step(1,1,1,1,1,1,1,0); check(3'b010, "R2 mg acquires during dev reset");
        step(0,0,0,0,0,0,0,1); check(3'b000, "R1 power-good clears mg");
    endtask

    task automatic t_priority;
        step(1,1,1,1,1,1,0,0); check(3'b100, "R8 all three contend");
        step(0,0,0,0,1,0,0,0); check(3'b000, "R6 hw release");
        step(1,1,1,1,0,0,0,0); check(3'b010, "R8 sw vs mg");
        step(0,0,1,0,0,0,0,0); check(3'b000, "R6 mg release");
        step(1,1,0,0,1,1,0,0); check(3'b100, "R8 sw vs hw");
        step(0,0,0,0,1,0,0,0); check(3'b000, "R6 hw release");
        step(0,0,1,1,1,1,0,0); check(3'b100, "R8 mg vs hw");
        step(0,0,0,0,0,0,0,1); check(3'b000, "R1 power-good clears hw");
    endtask

    initial begin
        pwr_rst = 1; dev_rst = 0;
        sw_we = 0; sw_wd = 0; mg_we = 0; mg_wd = 0; hw_we = 0; hw_wd = 0;
        t_reset();
        t_sw_cycle();
        t_hw_load();
        t_dev_reset();
        t_priority();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule